// File: doc/BRIEF.md
# Raster Fill Engine

The engine is a register-triggered drawing accelerator for an 8-bit-per-pixel framebuffer. The framebuffer sits behind a single synchronous RAM port with one cycle of read latency. Software uses two 32-bit bus windows. The top address bit selects the window: 0 is the stipple window and 1 is the span window. Inside either window, a write with address bit 2 clear stores a colour word, and both windows share that colour. A write with address bit 2 set is a command. Its destination pixel address is bus address bits 22:3.

A stipple command takes its data word as a 32-bit mask. The engine writes the colour byte to each pixel whose mask bit is set and skips pixels whose bit is clear. A span command carries a source field and a length field. An all-ones source fills the span with the colour byte. Any other source copies the span forward from that source address. Work proceeds one memory access per clock. While an operation runs, `busy` is high and new command writes are held off with `req_ready` low. Colour writes and reads are still accepted during that time.

The control is a five-state machine:
- ST_IDLE waits for a command.
- ST_STIP writes one selected pixel per cycle.
- ST_FILL writes one span pixel per cycle.
- ST_CRD reads a source pixel, and ST_CWR writes that pixel to the destination.

The transitions are:
- ST_IDLE goes to ST_STIP on a stipple command, to ST_FILL on a fill command, and to ST_CRD on a copy command.
- ST_STIP returns to ST_IDLE once no mask bit remains set.
- ST_FILL returns to ST_IDLE after the last pixel.
- ST_CRD always goes to ST_CWR.
- ST_CWR goes back to ST_CRD, or to ST_IDLE after the last pixel.

Top module: `raster_fill_engine`

## Requirements
- R1: After reset, the engine is idle: `busy` is 0, `req_ready` is 1, `mem_en` is 0, and the stored colour byte is 0x00.
- R2: A full write with address bit 2 clear stores data bits 7:0 as the colour. It writes no pixel, does not raise `busy`, and is accepted even while busy.
- R3: A full write with address bit 2 set starts a command at destination pixel `addr[22:3]`. Address bit 23 selects stipple (0) or span (1). Pixel addresses wrap modulo 2^20.
- R4: For a stipple command, data bit 31-i set writes the colour byte to pixel dst+i, for i = 0..31. A pixel whose bit is clear keeps its content.
- R5: A stipple writes its selected pixels in ascending order, one per cycle, with no cycles spent on clear bits. `busy` lasts max(number of set bits, 1) cycles.
- R6: For a span command, the length is data bits 28:24 plus one. A source field (bits 23:0) of 0xFFFFFF fills the span with the colour byte in ascending order, one pixel per cycle, so `busy` lasts for the length in cycles.
- R7: Any other source field copies the span in ascending order. The engine reads pixel src+k, then writes it to dst+k in the following cycle. Overlapping ranges therefore propagate forward, and `busy` lasts twice the length in cycles.
- R8: While busy, a write with address bit 2 set sees `req_ready` low until the engine is idle. Reads and colour writes always see `req_ready` high.
- R9: An operation in flight uses the colour byte that was stored when its command was accepted.
- R10: A write whose byte enables are not all set, or whose address bits 1:0 are not zero, is accepted and has no effect.
- R11: Reads of either window return 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | PIX_AW+4 | Byte address: bit 23 window, bits 22:3 destination, bit 2 colour/command |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_rdata | output | 32 | Read data (always zero) |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PIX_AW | RAM pixel address |
| mem_wdata | output | PIX_W | RAM write data |
| mem_rdata | input | PIX_W | RAM read data, one cycle after a read |

## Verification
The assertions check the following on every cycle:
- the memory port is silent when idle;
- command writes are held off while busy;
- a colour write never starts work;
- each stipple cycle clears exactly one mask bit;
- a copy write lands at the same offset from the destination as the read before it had from the source;
- the span counter stays inside the length;
- the in-flight colour never changes.

Only the bench scenarios can show the following:
- the pixel values that end up in memory;
- the exact busy length for each kind of command;
- forward propagation through overlapping copies;
- wrap-around at the top of the address space;
- that partial or misaligned writes leave both the colour and the memory untouched.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    localparam int WORD_W   = 32;
    localparam int MASK_W   = 32;
    localparam int IDX_W    = $clog2(MASK_W);
    localparam int SRC_W    = 24;
    localparam int LENF_W   = 5;
    localparam int LENF_LSB = 24;
    localparam int LEN_W    = LENF_W + 1;
    localparam int CMD_BIT  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIP,
        ST_FILL,
        ST_CRD,
        ST_CWR
    } eng_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_COLOUR,
        REQ_CMD,
        REQ_READ
    } req_kind_e;
endpackage

// File: rtl/rfe_req_decode.sv
module rfe_req_decode
    import rfe_pkg::*;
#(
    parameter int PIX_AW = 20,
    localparam int ADDR_W = PIX_AW + 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [WORD_W-1:0] req_wdata,
    output req_kind_e         kind,
    output logic              is_span,
    output logic [PIX_AW-1:0] dst,
    output logic [MASK_W-1:0] mask,
    output logic [PIX_AW-1:0] src,
    output logic [LEN_W-1:0]  len,
    output logic              src_fill
);
    logic full_word;

    always_comb begin
        full_word = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
        if (!req_valid) begin
            kind = REQ_NONE;
        end else if (!req_write) begin
            kind = REQ_READ;
        end else if (!full_word) begin
            kind = REQ_NONE;
        end else if (req_addr[CMD_BIT]) begin
            kind = REQ_CMD;
        end else begin
            kind = REQ_COLOUR;
        end
    end

    assign is_span  = req_addr[ADDR_W-1];
    assign dst      = req_addr[PIX_AW+2:3];
    assign mask     = req_wdata[MASK_W-1:0];
    assign src      = req_wdata[PIX_AW-1:0];
    assign src_fill = &req_wdata[SRC_W-1:0];
    assign len      = LEN_W'(req_wdata[LENF_LSB +: LENF_W]) + LEN_W'(1);
endmodule

// File: rtl/rfe_stip_scan.sv
module rfe_stip_scan
    import rfe_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    output logic              any,
    output logic [IDX_W-1:0]  idx,
    output logic [MASK_W-1:0] rest
);
    logic [IDX_W-1:0] pos;

    // The highest set bit is the lowest pixel offset still pending.
    always_comb begin
        pos = '0;
        for (int b = 0; b < MASK_W; b++) begin
            if (mask[b]) begin
                pos = IDX_W'(b);
            end
        end
        any       = |mask;
        idx       = IDX_W'(MASK_W - 1) - pos;
        rest      = mask;
        rest[pos] = 1'b0;
    end
endmodule

// File: rtl/rfe_span_ctr.sv
module rfe_span_ctr
    import rfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic [LEN_W-1:0] cnt,
    output logic             last
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt   <= '0;
            len_q <= len_in;
        end else if (step && !last) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    assign last = (cnt == len_q - LEN_W'(1));

    // R6: the pixel counter never runs past the programmed length
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) |-> (cnt < len_q));
endmodule

// File: rtl/raster_fill_engine.sv
module raster_fill_engine
    import rfe_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int PIX_W  = 8,
    localparam int ADDR_W = PIX_AW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [WORD_W-1:0] req_rdata,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata
);
    eng_state_e state, state_nx;

    req_kind_e         dec_kind;
    logic              dec_span;
    logic [PIX_AW-1:0] dec_dst;
    logic [MASK_W-1:0] dec_mask;
    logic [PIX_AW-1:0] dec_src;
    logic [LEN_W-1:0]  dec_len;
    logic              dec_fill;

    logic [PIX_W-1:0]  colour_q;
    logic [PIX_W-1:0]  op_col;
    logic [PIX_AW-1:0] dst_q;
    logic [PIX_AW-1:0] src_q;
    logic [MASK_W-1:0] mask_q;

    logic              scan_any;
    logic [IDX_W-1:0]  scan_idx;
    logic [MASK_W-1:0] scan_rest;

    logic [LEN_W-1:0]  cnt;
    logic              cnt_last;
    logic              cnt_step;

    logic accept;
    logic colour_acc;
    logic cmd_acc;

    rfe_req_decode #(.PIX_AW(PIX_AW)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .kind      (dec_kind),
        .is_span   (dec_span),
        .dst       (dec_dst),
        .mask      (dec_mask),
        .src       (dec_src),
        .len       (dec_len),
        .src_fill  (dec_fill)
    );

    rfe_stip_scan u_scan (
        .mask (mask_q),
        .any  (scan_any),
        .idx  (scan_idx),
        .rest (scan_rest)
    );

    assign cnt_step = (state == ST_FILL) || (state == ST_CWR);

    rfe_span_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cmd_acc),
        .len_in (dec_len),
        .step   (cnt_step),
        .cnt    (cnt),
        .last   (cnt_last)
    );

    // Handshake
    assign busy       = (state != ST_IDLE);
    assign req_ready  = !busy || !(req_write && req_addr[CMD_BIT]);
    assign req_rdata  = '0;
    assign accept     = req_valid && req_ready;
    assign colour_acc = accept && (dec_kind == REQ_COLOUR);
    assign cmd_acc    = accept && (dec_kind == REQ_CMD);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_acc) begin
                    if (!dec_span) begin
                        state_nx = ST_STIP;
                    end else if (dec_fill) begin
                        state_nx = ST_FILL;
                    end else begin
                        state_nx = ST_CRD;
                    end
                end
            end
            ST_STIP: begin
                if (!scan_any || (scan_rest == '0)) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_FILL: begin
                if (cnt_last) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CRD: begin
                state_nx = ST_CWR;
            end
            ST_CWR: begin
                state_nx = cnt_last ? ST_IDLE : ST_CRD;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            colour_q <= '0;
            op_col   <= '0;
            dst_q    <= '0;
            src_q    <= '0;
            mask_q   <= '0;
        end else begin
            if (colour_acc) begin
                colour_q <= req_wdata[PIX_W-1:0];
            end
            if (cmd_acc) begin
                op_col <= colour_q;
                dst_q  <= dec_dst;
                src_q  <= dec_src;
                mask_q <= dec_span ? '0 : dec_mask;
            end else if (state == ST_STIP) begin
                mask_q <= scan_rest;
            end
        end
    end

    // Memory port outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                mem_en = 1'b0;
            end
            ST_STIP: begin
                mem_en    = scan_any;
                mem_we    = scan_any;
                mem_addr  = dst_q + PIX_AW'(scan_idx);
                mem_wdata = op_col;
            end
            ST_FILL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q + PIX_AW'(cnt);
                mem_wdata = op_col;
            end
            ST_CRD: begin
                mem_en   = 1'b1;
                mem_addr = src_q + PIX_AW'(cnt);
            end
            ST_CWR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q + PIX_AW'(cnt);
                mem_wdata = mem_rdata;
            end
            default: mem_en = 1'b0;
        endcase
    end

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_en);

    // R8: command writes are held off while busy
    a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && req_write && req_addr[CMD_BIT]) |-> !req_ready);

    // R2: a colour write taken while idle starts nothing
    a_r2_colour_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_ready && dec_kind == REQ_COLOUR) |=> !busy);

    // R5: every stipple cycle with work retires exactly one mask bit
    a_r5_one_bit_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STIP && mask_q != '0) |=>
            ($countones(mask_q) == $countones($past(mask_q)) - 1));

    // R7: a copy write sits at the offset of the read just before it
    a_r7_copy_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CWR) |->
            ($past(mem_en && !mem_we) && (mem_addr - dst_q == $past(mem_addr) - src_q)));

    // R9: colour of an operation in flight never changes
    a_r9_colour_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_col));
endmodule

// File: tb/raster_fill_engine_tb.sv
module raster_fill_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_AW     = 20;
    localparam int ADDR_W     = PIX_AW + 4;
    localparam int AMASK      = (1 << PIX_AW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_be = 4'h0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready;
    logic [31:0]       req_rdata;
    logic              busy;
    logic              mem_en;
    logic              mem_we;
    logic [PIX_AW-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;

    raster_fill_engine #(.PIX_AW(PIX_AW), .PIX_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] ram [int];
    logic [7:0] sh  [int];
    int q_dst [$];
    int q_src [$];
    int q_col [$];
    int busy_left = 0;
    logic [7:0] m_colour = 8'h00;

    function automatic logic [7:0] pre(int a);
        return 8'((a * 7) + 3);
    endfunction

    function automatic logic [7:0] ram_rd(int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    function automatic logic [7:0] sh_rd(int a);
        return sh.exists(a) ? sh[a] : 8'h00;
    endfunction

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // RAM with one cycle read latency
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            ram[int'(mem_addr)] = mem_wdata;
        end else if (mem_en) begin
            mem_rdata <= ram_rd(int'(mem_addr));
        end
    end

    task automatic model_cmd();
        int dst;
        int pc;
        int len;
        int src;
        dst = int'(req_addr >> 3) & AMASK;
        if (!req_addr[ADDR_W-1]) begin
            pc = 0;
            for (int i = 0; i < 32; i++) begin
                if (req_wdata[31-i]) begin
                    q_dst.push_back((dst + i) & AMASK);
                    q_src.push_back(-1);
                    q_col.push_back(int'(m_colour));
                    pc++;
                end
            end
            busy_left = (pc == 0) ? 1 : pc;
        end else begin
            len = int'(req_wdata[28:24]) + 1;
            src = int'(req_wdata[23:0]);
            for (int k = 0; k < len; k++) begin
                q_dst.push_back((dst + k) & AMASK);
                q_src.push_back((src == 24'hFFFFFF) ? -1 : ((src + k) & AMASK));
                q_col.push_back(int'(m_colour));
            end
            busy_left = (src == 24'hFFFFFF) ? len : 2 * len;
        end
    endtask

    // Cycle-by-cycle reference comparison, sampled before each rising edge
    always begin
        logic exp_busy;
        int d;
        int s;
        int c;
        int e;
        @(negedge clk);
        #3;
        if (rst_n) begin
            exp_busy = (busy_left > 0);
            check_eq("R8", "busy", busy, exp_busy);
            if (busy_left > 0) busy_left--;
            if (req_valid) begin
                check_eq("R8", "ready", req_ready, !exp_busy || !(req_write && req_addr[2]));
            end
            if (mem_en && mem_we) begin
                if (q_dst.size() == 0) begin
                    check_eq("R5", "unexpected write", int'(mem_addr), -1);
                end else begin
                    d = q_dst.pop_front();
                    s = q_src.pop_front();
                    c = q_col.pop_front();
                    e = (s < 0) ? c : int'(sh_rd(s));
                    check_eq("R4", "write addr", int'(mem_addr), d);
                    check_eq("R6", "write data", mem_wdata, e);
                    sh[d] = 8'(e);
                end
            end else if (mem_en) begin
                check_eq("R7", "copy read addr", int'(mem_addr), (q_src.size() > 0) ? q_src[0] : -1);
            end
            if (req_valid && req_ready) begin
                if (!req_write) begin
                    check_eq("R11", "read data", req_rdata, 0);
                end else if (req_be == 4'hF && req_addr[1:0] == 2'b00) begin
                    if (!req_addr[2]) m_colour = req_wdata[7:0];
                    else model_cmd();
                end
            end
        end
    end

    task automatic bus_op(bit wr, logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] be);
        bit got;
        @(negedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (1) begin
            #2;
            got = req_ready;
            @(posedge clk);
            if (got) break;
        end
        #1;
        req_valid = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] cmd_addr(bit span, int dst);
        return {span, 20'(dst), 1'b1, 2'b00};
    endfunction

    localparam logic [ADDR_W-1:0] COL_ADDR = '0;

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (1) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    int nb;

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ram[i] = pre(i);
            sh[i]  = pre(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1 reset state
        check_eq("R1", "busy after reset", busy, 0);
        check_eq("R1", "ready after reset", req_ready, 1);
        check_eq("R1", "mem_en after reset", mem_en, 0);

        // R1 colour resets to zero: fill two pixels at 0x200
        bus_op(1, cmd_addr(1, 'h200), {3'b0, 5'd1, 24'hFFFFFF}, 4'hF);
        wait_idle();
        check_eq("R1", "reset colour pixel", ram_rd('h200), 8'h00);

        // R2 colour write leaves engine idle
        bus_op(1, COL_ADDR, 32'hFFFFFFAB, 4'hF);
        @(negedge clk);
        check_eq("R2", "busy after colour", busy, 0);

        // R4, R3: stipple at 0x40 with first and last bits
        bus_op(1, cmd_addr(0, 'h40), 32'h80000001, 4'hF);
        wait_idle();
        check_eq("R4", "stipple first pixel", ram_rd('h40), 8'hAB);
        check_eq("R4", "stipple last pixel", ram_rd('h5F), 8'hAB);
        check_eq("R4", "stipple clear pixel", ram_rd('h41), pre('h41));

        // R5: busy length for full and empty masks
        bus_op(1, cmd_addr(0, 'h300), 32'hFFFFFFFF, 4'hF);
        measure_busy(nb);
        check_eq("R5", "full mask busy cycles", nb, 32);
        bus_op(1, cmd_addr(0, 'h340), 32'h0, 4'hF);
        measure_busy(nb);
        check_eq("R5", "empty mask busy cycles", nb, 1);
        check_eq("R5", "empty mask no write", ram_rd('h340), pre('h340));

        // R6: fill 4 pixels at 0x80
        bus_op(1, COL_ADDR, 32'h0000005C, 4'hF);
        bus_op(1, cmd_addr(1, 'h80), {3'b0, 5'd3, 24'hFFFFFF}, 4'hF);
        measure_busy(nb);
        check_eq("R6", "fill busy cycles", nb, 4);
        check_eq("R6", "fill first", ram_rd('h80), 8'h5C);
        check_eq("R6", "fill last", ram_rd('h83), 8'h5C);
        check_eq("R6", "fill beyond", ram_rd('h84), pre('h84));

        // R7: 32-pixel copy from 0x10 to 0x100
        bus_op(1, cmd_addr(1, 'h100), {3'b0, 5'd31, 24'h000010}, 4'hF);
        measure_busy(nb);
        check_eq("R7", "copy busy cycles", nb, 64);
        check_eq("R7", "copy first", ram_rd('h100), pre('h10));
        check_eq("R7", "copy last", ram_rd('h11F), pre('h2F));
        check_eq("R7", "copy beyond", ram_rd('h120), pre('h120));

        // R7: overlapping forward copy propagates the first byte
        bus_op(1, cmd_addr(1, 'h21), {3'b0, 5'd3, 24'h000020}, 4'hF);
        wait_idle();
        check_eq("R7", "overlap pixel 0x21", ram_rd('h21), pre('h20));
        check_eq("R7", "overlap pixel 0x24", ram_rd('h24), pre('h20));

        // R9, R8: colour written mid-fill does not affect the fill
        bus_op(1, COL_ADDR, 32'h00000011, 4'hF);
        bus_op(1, cmd_addr(1, 'h180), {3'b0, 5'd31, 24'hFFFFFF}, 4'hF);
        bus_op(1, COL_ADDR, 32'h00000022, 4'hF);
        check_eq("R8", "colour accepted while busy", busy, 1);
        wait_idle();
        check_eq("R9", "in-flight colour", ram_rd('h19F), 8'h11);
        bus_op(1, cmd_addr(1, 'h1A0), {3'b0, 5'd0, 24'hFFFFFF}, 4'hF);
        wait_idle();
        check_eq("R2", "new colour used", ram_rd('h1A0), 8'h22);

        // R8: back-to-back commands stall then run
        bus_op(1, cmd_addr(1, 'h1C0), {3'b0, 5'd7, 24'hFFFFFF}, 4'hF);
        bus_op(1, cmd_addr(0, 'h1D0), 32'hF0000000, 4'hF);
        wait_idle();
        check_eq("R8", "second command ran", ram_rd('h1D3), 8'h22);
        check_eq("R8", "first command ran", ram_rd('h1C7), 8'h22);

        // R10: partial and misaligned writes are ignored
        bus_op(1, COL_ADDR, 32'h00000033, 4'h7);
        bus_op(1, COL_ADDR | 1, 32'h00000044, 4'hF);
        bus_op(1, cmd_addr(1, 'h1B0), {3'b0, 5'd0, 24'hFFFFFF}, 4'hE);
        @(negedge clk);
        check_eq("R10", "partial command idle", busy, 0);
        check_eq("R10", "partial command no write", ram_rd('h1B0), pre('h1B0));
        bus_op(1, cmd_addr(1, 'h1B1), {3'b0, 5'd0, 24'hFFFFFF}, 4'hF);
        wait_idle();
        check_eq("R10", "colour unchanged", ram_rd('h1B1), 8'h22);

        // R11: reads return zero and start nothing
        bus_op(0, cmd_addr(1, 'h1B2), 32'h0, 4'hF);
        @(negedge clk);
        check_eq("R11", "read starts nothing", busy, 0);

        // R3: address wrap at the top of pixel space
        bus_op(1, cmd_addr(1, 'hFFFFF), {3'b0, 5'd1, 24'hFFFFFF}, 4'hF);
        wait_idle();
        check_eq("R3", "wrap top pixel", ram_rd('hFFFFF), 8'h22);
        check_eq("R3", "wrap to zero", ram_rd(0), 8'h22);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule